// File: doc/BRIEF.md
# DMA Descriptor and Header Cache Arbiter

This block decides, on every clock cycle, which DMA channel may use each of two small on-chip memories. One memory caches DMA descriptors and the other caches packet headers for transmit segmentation offload. Each transmit or receive channel can ask for four kinds of access. It can write a descriptor that has just arrived from system memory into the descriptor cache, or read a prefetched descriptor out of it. It can write a header that has just arrived from system memory into the header cache, or read a cached header out of it. Header accesses come only from transmit channels that have segmentation offload switched on.

All request and configuration inputs are captured in one register stage. The grants are then decoded without further registers. A request presented before a rising edge is therefore granted or refused for the cycle that follows that edge.

Cache fills carry data arriving on the system bus, so they beat reads, and only one fill can be taken per cycle. The two caches share a single read slot. A read runs on whichever cache port a fill has left free. When both ports are free, a configuration bit picks which cache is read. A second configuration bit picks which direction wins descriptor accesses. Inside any group of requesters, the highest channel index wins. Each grant output is a one-hot (or all-zero) vector with one bit per channel.

Top module: `dca_arbiter`

## Requirements
- R1: Grants reflect the inputs sampled at the most recent rising edge. While `rst` is high and in the cycle after it, and whenever no request was sampled, every grant output is zero.
- R2: Across all fill grant outputs (`tx_dfill_gnt`, `rx_dfill_gnt`, `tx_hfill_gnt`), at most one bit is set per cycle. A pending descriptor fill is always granted, and a header fill is granted only when no descriptor fill is pending.
- R3: When a descriptor fill is granted, no descriptor read is granted. When a header fill is granted, no header read is granted.
- R4: When descriptor and header reads are both pending and neither fill is granted, exactly one read is granted. With `cfg_hdr_rd_first` = 0 the descriptor read wins, and with `cfg_hdr_rd_first` = 1 the header read wins.
- R5: When a fill occupies one cache port, a pending read of the other cache is granted whatever the value of `cfg_hdr_rd_first`.
- R6: For descriptor reads and descriptor fills, `cfg_tx_first` = 0 makes any RX requester beat every TX requester. `cfg_tx_first` = 1 makes any TX requester beat every RX requester.
- R7: Within one group (TX or RX) requesting the same class, only the requester with the highest channel index (bit position in the vector) is granted.
- R8: A header fill or header read request from a TX channel whose `tx_seg_en` bit is 0 is ignored. It receives no grant and blocks no other request.
- R9: A grant bit is set only for a channel that raised that class of request at the sampling edge, and at most one read grant bit is set across `tx_drd_gnt`, `rx_drd_gnt` and `tx_hrd_gnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hdr_rd_first | input | 1 | 0: descriptor read beats header read; 1: header read beats descriptor read |
| cfg_tx_first | input | 1 | 0: RX beats TX on descriptor accesses; 1: TX beats RX |
| tx_seg_en | input | NTX | Segmentation offload enable per TX channel |
| tx_dfill_req | input | NTX | Descriptor fill write request per TX channel |
| rx_dfill_req | input | NRX | Descriptor fill write request per RX channel |
| tx_drd_req | input | NTX | Descriptor read request per TX channel |
| rx_drd_req | input | NRX | Descriptor read request per RX channel |
| tx_hfill_req | input | NTX | Header fill write request per TX channel |
| tx_hrd_req | input | NTX | Header read request per TX channel |
| tx_dfill_gnt | output | NTX | Descriptor fill grant per TX channel |
| rx_dfill_gnt | output | NRX | Descriptor fill grant per RX channel |
| tx_drd_gnt | output | NTX | Descriptor read grant per TX channel |
| rx_drd_gnt | output | NRX | Descriptor read grant per RX channel |
| tx_hfill_gnt | output | NTX | Header fill grant per TX channel |
| tx_hrd_gnt | output | NTX | Header read grant per TX channel |

## Verification
Every grant is due in the cycle right after the rising edge that captured its requests and configuration bits. No grant depends on anything sampled at an earlier edge. Each scenario therefore drives its inputs on a falling edge, waits for the next rising edge plus a small delay, and compares all six grant vectors there. The latency scenario also checks the grants just before that edge, to confirm that they still show the previous request. Reset and priority-bit scenarios reload the inputs every cycle, so no result carries over between checks.

// File: rtl/dca_pkg.sv
package dca_pkg;

  typedef enum logic {
    RD_DESC_FIRST = 1'b0,
    RD_HDR_FIRST  = 1'b1
  } rd_pref_e;

  typedef enum logic {
    DIR_RX_FIRST = 1'b0,
    DIR_TX_FIRST = 1'b1
  } dir_pref_e;

endpackage

// File: rtl/dca_in_reg.sv
module dca_in_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/dca_prio_pick.sv
// Fixed-priority picker: the highest set index wins.
module dca_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == N - 1) begin : g_top
      assign gnt[i] = req[i];
    end else begin : g_low
      assign gnt[i] = req[i] & ~(|req[N-1:i+1]);
    end
  end

endmodule

// File: rtl/dca_dir_pick.sv
// Two-group picker: a direction bit picks the winning group,
// and the highest index wins inside that group.
module dca_dir_pick
  import dca_pkg::*;
#(
  parameter int NTX = 4,
  parameter int NRX = 4
) (
  input  logic           en,
  input  dir_pref_e      pref,
  input  logic [NTX-1:0] tx_req,
  input  logic [NRX-1:0] rx_req,
  output logic [NTX-1:0] tx_gnt,
  output logic [NRX-1:0] rx_gnt
);

  logic [NTX-1:0] tx_pick;
  logic [NRX-1:0] rx_pick;
  logic           tx_any, rx_any, tx_win, rx_win;

  dca_prio_pick #(.N(NTX)) u_tx (.req(tx_req), .gnt(tx_pick));
  dca_prio_pick #(.N(NRX)) u_rx (.req(rx_req), .gnt(rx_pick));

  always_comb begin
    tx_any = |tx_req;
    rx_any = |rx_req;
    tx_win = en & tx_any & ((pref == DIR_TX_FIRST) | ~rx_any);
    rx_win = en & rx_any & ~tx_win;
    tx_gnt = tx_pick & {NTX{tx_win}};
    rx_gnt = rx_pick & {NRX{rx_win}};
  end

endmodule

// File: rtl/dca_grant_core.sv
// Combinational grant decode for both cache ports.
module dca_grant_core
  import dca_pkg::*;
#(
  parameter int NTX = 4,
  parameter int NRX = 4
) (
  input  rd_pref_e       rd_pref,
  input  dir_pref_e      dir_pref,
  input  logic [NTX-1:0] seg_en,
  input  logic [NTX-1:0] tx_dfill,
  input  logic [NRX-1:0] rx_dfill,
  input  logic [NTX-1:0] tx_drd,
  input  logic [NRX-1:0] rx_drd,
  input  logic [NTX-1:0] tx_hfill,
  input  logic [NTX-1:0] tx_hrd,
  output logic [NTX-1:0] tx_dfill_g,
  output logic [NRX-1:0] rx_dfill_g,
  output logic [NTX-1:0] tx_drd_g,
  output logic [NRX-1:0] rx_drd_g,
  output logic [NTX-1:0] tx_hfill_g,
  output logic [NTX-1:0] tx_hrd_g
);

  logic [NTX-1:0] hfill_ok, hrd_ok, hfill_pick, hrd_pick;
  logic           desc_busy, hdr_busy, drd_any, hrd_any;
  logic           drd_en, hrd_en;

  always_comb begin
    hfill_ok  = tx_hfill & seg_en;
    hrd_ok    = tx_hrd & seg_en;
    desc_busy = (|tx_dfill) | (|rx_dfill);
    hdr_busy  = (|hfill_ok) & ~desc_busy;
    drd_any   = (|tx_drd) | (|rx_drd);
    hrd_any   = |hrd_ok;
    // one shared read slot; the preference bit only matters when both ports are free
    drd_en = ~desc_busy & (hdr_busy | ~hrd_any | (rd_pref == RD_DESC_FIRST));
    hrd_en = ~hdr_busy & (desc_busy | ~drd_any | (rd_pref == RD_HDR_FIRST));
  end

  dca_dir_pick #(.NTX(NTX), .NRX(NRX)) u_dfill (
    .en(1'b1), .pref(dir_pref), .tx_req(tx_dfill), .rx_req(rx_dfill),
    .tx_gnt(tx_dfill_g), .rx_gnt(rx_dfill_g)
  );

  dca_dir_pick #(.NTX(NTX), .NRX(NRX)) u_drd (
    .en(drd_en), .pref(dir_pref), .tx_req(tx_drd), .rx_req(rx_drd),
    .tx_gnt(tx_drd_g), .rx_gnt(rx_drd_g)
  );

  dca_prio_pick #(.N(NTX)) u_hfill (.req(hfill_ok), .gnt(hfill_pick));
  dca_prio_pick #(.N(NTX)) u_hrd   (.req(hrd_ok),   .gnt(hrd_pick));

  assign tx_hfill_g = hfill_pick & {NTX{hdr_busy}};
  assign tx_hrd_g   = hrd_pick & {NTX{hrd_en}};

endmodule

// File: rtl/dca_arbiter.sv
module dca_arbiter
  import dca_pkg::*;
#(
  parameter int NTX = 4,
  parameter int NRX = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_hdr_rd_first,
  input  logic           cfg_tx_first,
  input  logic [NTX-1:0] tx_seg_en,
  input  logic [NTX-1:0] tx_dfill_req,
  input  logic [NRX-1:0] rx_dfill_req,
  input  logic [NTX-1:0] tx_drd_req,
  input  logic [NRX-1:0] rx_drd_req,
  input  logic [NTX-1:0] tx_hfill_req,
  input  logic [NTX-1:0] tx_hrd_req,
  output logic [NTX-1:0] tx_dfill_gnt,
  output logic [NRX-1:0] rx_dfill_gnt,
  output logic [NTX-1:0] tx_drd_gnt,
  output logic [NRX-1:0] rx_drd_gnt,
  output logic [NTX-1:0] tx_hfill_gnt,
  output logic [NTX-1:0] tx_hrd_gnt
);

  localparam int IW = 2 + 5 * NTX + 2 * NRX;

  logic [IW-1:0]  in_d, in_q;
  logic           q_hdr_first, q_tx_first;
  logic [NTX-1:0] q_seg, q_tx_dfill, q_tx_drd, q_tx_hfill, q_tx_hrd;
  logic [NRX-1:0] q_rx_dfill, q_rx_drd;
  rd_pref_e       rd_pref;
  dir_pref_e      dir_pref;

  assign in_d = {cfg_hdr_rd_first, cfg_tx_first, tx_seg_en, tx_dfill_req,
                 rx_dfill_req, tx_drd_req, rx_drd_req, tx_hfill_req, tx_hrd_req};

  dca_in_reg #(.W(IW)) u_in (.clk(clk), .rst(rst), .d(in_d), .q(in_q));

  assign {q_hdr_first, q_tx_first, q_seg, q_tx_dfill,
          q_rx_dfill, q_tx_drd, q_rx_drd, q_tx_hfill, q_tx_hrd} = in_q;

  assign rd_pref  = q_hdr_first ? RD_HDR_FIRST : RD_DESC_FIRST;
  assign dir_pref = q_tx_first  ? DIR_TX_FIRST : DIR_RX_FIRST;

  dca_grant_core #(.NTX(NTX), .NRX(NRX)) u_core (
    .rd_pref(rd_pref), .dir_pref(dir_pref), .seg_en(q_seg),
    .tx_dfill(q_tx_dfill), .rx_dfill(q_rx_dfill),
    .tx_drd(q_tx_drd), .rx_drd(q_rx_drd),
    .tx_hfill(q_tx_hfill), .tx_hrd(q_tx_hrd),
    .tx_dfill_g(tx_dfill_gnt), .rx_dfill_g(rx_dfill_gnt),
    .tx_drd_g(tx_drd_gnt), .rx_drd_g(rx_drd_gnt),
    .tx_hfill_g(tx_hfill_gnt), .tx_hrd_g(tx_hrd_gnt)
  );

endmodule

// File: rtl/dca_arbiter_chk.sv
module dca_arbiter_chk #(
  parameter int NTX = 4,
  parameter int NRX = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [NTX-1:0] tx_seg_en,
  input logic [NTX-1:0] tx_dfill_req,
  input logic [NRX-1:0] rx_dfill_req,
  input logic [NTX-1:0] tx_drd_req,
  input logic [NRX-1:0] rx_drd_req,
  input logic [NTX-1:0] tx_hfill_req,
  input logic [NTX-1:0] tx_hrd_req,
  input logic [NTX-1:0] tx_dfill_gnt,
  input logic [NRX-1:0] rx_dfill_gnt,
  input logic [NTX-1:0] tx_drd_gnt,
  input logic [NRX-1:0] rx_drd_gnt,
  input logic [NTX-1:0] tx_hfill_gnt,
  input logic [NTX-1:0] tx_hrd_gnt
);

  AST_ONE_FILL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_dfill_gnt, rx_dfill_gnt, tx_hfill_gnt}));  // R2

  AST_DFILL_SERVED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past((|tx_dfill_req) | (|rx_dfill_req)))
      |-> ((|tx_dfill_gnt) | (|rx_dfill_gnt)));  // R2

  AST_DFILL_BLOCKS_DRD: assert property (@(posedge clk) disable iff (rst)
    ((|tx_dfill_gnt) | (|rx_dfill_gnt)) |-> !((|tx_drd_gnt) | (|rx_drd_gnt)));  // R3

  AST_HFILL_BLOCKS_HRD: assert property (@(posedge clk) disable iff (rst)
    (|tx_hfill_gnt) |-> !(|tx_hrd_gnt));  // R3

  AST_CROSS_READ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ((|tx_dfill_gnt) | (|rx_dfill_gnt))
      && $past(|(tx_hrd_req & tx_seg_en))) |-> (|tx_hrd_gnt));  // R5

  AST_SEG_GATE: assert property (@(posedge clk) disable iff (rst)
    ((tx_hrd_gnt | tx_hfill_gnt) & ~$past(tx_seg_en)) == '0);  // R8

  AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    (((tx_drd_gnt & ~$past(tx_drd_req)) == '0)
      && ((rx_drd_gnt & ~$past(rx_drd_req)) == '0)
      && ((tx_dfill_gnt & ~$past(tx_dfill_req)) == '0)
      && ((rx_dfill_gnt & ~$past(rx_dfill_req)) == '0)
      && ((tx_hfill_gnt & ~$past(tx_hfill_req)) == '0)
      && ((tx_hrd_gnt & ~$past(tx_hrd_req)) == '0)));  // R9

  AST_ONE_READ: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_drd_gnt, rx_drd_gnt, tx_hrd_gnt}));  // R9

endmodule

bind dca_arbiter dca_arbiter_chk #(.NTX(NTX), .NRX(NRX)) u_chk (
  .clk(clk), .rst(rst), .tx_seg_en(tx_seg_en),
  .tx_dfill_req(tx_dfill_req), .rx_dfill_req(rx_dfill_req),
  .tx_drd_req(tx_drd_req), .rx_drd_req(rx_drd_req),
  .tx_hfill_req(tx_hfill_req), .tx_hrd_req(tx_hrd_req),
  .tx_dfill_gnt(tx_dfill_gnt), .rx_dfill_gnt(rx_dfill_gnt),
  .tx_drd_gnt(tx_drd_gnt), .rx_drd_gnt(rx_drd_gnt),
  .tx_hfill_gnt(tx_hfill_gnt), .tx_hrd_gnt(tx_hrd_gnt)
);

// File: tb/tb_dca_arbiter.sv
`timescale 1ns/1ps
module tb_dca_arbiter;

  localparam int NTX = 4;
  localparam int NRX = 3;

  logic clk = 1'b0;
  logic rst;
  logic cfg_hdr_rd_first, cfg_tx_first;
  logic [NTX-1:0] tx_seg_en, tx_dfill_req, tx_drd_req, tx_hfill_req, tx_hrd_req;
  logic [NRX-1:0] rx_dfill_req, rx_drd_req;
  logic [NTX-1:0] tx_dfill_gnt, tx_drd_gnt, tx_hfill_gnt, tx_hrd_gnt;
  logic [NRX-1:0] rx_dfill_gnt, rx_drd_gnt;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  dca_arbiter #(.NTX(NTX), .NRX(NRX)) dut (
    .clk(clk), .rst(rst),
    .cfg_hdr_rd_first(cfg_hdr_rd_first), .cfg_tx_first(cfg_tx_first),
    .tx_seg_en(tx_seg_en),
    .tx_dfill_req(tx_dfill_req), .rx_dfill_req(rx_dfill_req),
    .tx_drd_req(tx_drd_req), .rx_drd_req(rx_drd_req),
    .tx_hfill_req(tx_hfill_req), .tx_hrd_req(tx_hrd_req),
    .tx_dfill_gnt(tx_dfill_gnt), .rx_dfill_gnt(rx_dfill_gnt),
    .tx_drd_gnt(tx_drd_gnt), .rx_drd_gnt(rx_drd_gnt),
    .tx_hfill_gnt(tx_hfill_gnt), .tx_hrd_gnt(tx_hrd_gnt)
  );

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // checks all six grant vectors in one go
  task automatic chk_all(string tag, logic [7:0] e_tdf, logic [7:0] e_rdf,
                         logic [7:0] e_tdr, logic [7:0] e_rdr,
                         logic [7:0] e_thf, logic [7:0] e_thr);
    chk(tag, "tx_dfill_gnt", 8'(tx_dfill_gnt), e_tdf);
    chk(tag, "rx_dfill_gnt", 8'(rx_dfill_gnt), e_rdf);
    chk(tag, "tx_drd_gnt",   8'(tx_drd_gnt),   e_tdr);
    chk(tag, "rx_drd_gnt",   8'(rx_drd_gnt),   e_rdr);
    chk(tag, "tx_hfill_gnt", 8'(tx_hfill_gnt), e_thf);
    chk(tag, "tx_hrd_gnt",   8'(tx_hrd_gnt),   e_thr);
  endtask

  task automatic clear_in();
    cfg_hdr_rd_first = 1'b0; cfg_tx_first = 1'b0;
    tx_seg_en = '1;
    tx_dfill_req = '0; rx_dfill_req = '0; tx_drd_req = '0;
    rx_drd_req = '0; tx_hfill_req = '0; tx_hrd_req = '0;
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; clear_in();
    tx_drd_req = 4'b1000; tx_dfill_req = 4'b0001; tx_hrd_req = 4'b0010;
    settle();
    chk_all("R1 reset", 0, 0, 0, 0, 0, 0);
    @(negedge clk); rst = 1'b0; clear_in();
    settle();
    chk_all("R1 idle", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_latency();
    @(negedge clk); clear_in(); tx_drd_req = 4'b0010;
    #3;
    chk("R1 before edge", "tx_drd_gnt", 8'(tx_drd_gnt), 8'h00);
    settle();
    chk_all("R1 after edge", 0, 0, 8'b0010, 0, 0, 0);
  endtask

  task automatic t_fill_excl();
    @(negedge clk); clear_in();
    tx_dfill_req = 4'b0100; tx_hfill_req = 4'b1000;
    settle();
    chk_all("R2 dfill beats hfill", 8'b0100, 0, 0, 0, 0, 0);
    @(negedge clk); clear_in(); tx_hfill_req = 4'b1010;
    settle();
    chk_all("R7 hfill highest index", 0, 0, 0, 0, 8'b1000, 0);
  endtask

  task automatic t_fill_block();
    @(negedge clk); clear_in();
    rx_dfill_req = 3'b001; rx_drd_req = 3'b100;
    settle();
    chk_all("R3 dfill blocks drd", 0, 8'b001, 0, 0, 0, 0);
    @(negedge clk); clear_in();
    tx_hfill_req = 4'b0001; tx_hrd_req = 4'b0100; tx_drd_req = 4'b0010;
    cfg_hdr_rd_first = 1'b1;
    settle();
    chk_all("R3 R5 hfill blocks hrd", 0, 0, 8'b0010, 0, 8'b0001, 0);
  endtask

  task automatic t_read_prio();
    @(negedge clk); clear_in();
    tx_drd_req = 4'b0001; tx_hrd_req = 4'b0010; cfg_hdr_rd_first = 1'b0;
    settle();
    chk_all("R4 desc read first", 0, 0, 8'b0001, 0, 0, 0);
    @(negedge clk); cfg_hdr_rd_first = 1'b1;
    settle();
    chk_all("R4 header read first", 0, 0, 0, 0, 0, 8'b0010);
  endtask

  task automatic t_cross();
    @(negedge clk); clear_in();
    tx_dfill_req = 4'b1000; rx_drd_req = 3'b010; tx_hrd_req = 4'b0001;
    cfg_hdr_rd_first = 1'b0;
    settle();
    chk_all("R5 header read on free port", 8'b1000, 0, 0, 0, 0, 8'b0001);
  endtask

  task automatic t_dir();
    @(negedge clk); clear_in();
    tx_drd_req = 4'b0101; rx_drd_req = 3'b011; cfg_tx_first = 1'b0;
    settle();
    chk_all("R6 R7 rx first read", 0, 0, 0, 8'b010, 0, 0);
    @(negedge clk); cfg_tx_first = 1'b1;
    settle();
    chk_all("R6 R7 tx first read", 0, 0, 8'b0100, 0, 0, 0);
    @(negedge clk); clear_in();
    tx_dfill_req = 4'b0001; rx_dfill_req = 3'b101; cfg_tx_first = 1'b0;
    settle();
    chk_all("R6 R7 rx first fill", 0, 8'b100, 0, 0, 0, 0);
    @(negedge clk); cfg_tx_first = 1'b1;
    settle();
    chk_all("R6 tx first fill", 8'b0001, 0, 0, 0, 0, 0);
  endtask

  task automatic t_seg();
    @(negedge clk); clear_in();
    tx_seg_en = 4'b0111; tx_hrd_req = 4'b1010;
    settle();
    chk_all("R8 masked hrd channel", 0, 0, 0, 0, 0, 8'b0010);
    @(negedge clk); clear_in();
    tx_seg_en = 4'b0111; tx_hfill_req = 4'b1000; tx_hrd_req = 4'b1000;
    rx_drd_req = 3'b001; cfg_hdr_rd_first = 1'b1;
    settle();
    chk_all("R8 masked header blocks nothing", 0, 0, 0, 8'b001, 0, 0);
  endtask

  initial begin
    rst = 1'b1; clear_in();
    repeat (3) @(posedge clk);
    t_reset();
    t_latency();
    t_fill_excl();
    t_fill_block();
    t_read_prio();
    t_cross();
    t_dir();
    t_seg();
    @(negedge clk); clear_in();
    settle();
    chk_all("R1 idle end", 0, 0, 0, 0, 0, 0);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule